// File: doc/BRIEF.md
# Serial DAC Command Front End

This block is the digital side of a single-channel serial-input digital-to-analog converter. A host shifts a frame in on a data line, one bit per rising edge of a serial clock, while an active-low select line is held low. When the select line returns high, the block decodes the frame. Depending on the command, it loads a staging (input) register, copies staging into the converter register, or does both in one step. Other commands set the power-down state or the reference choice. The converter register drives the code output that feeds the analog core.

A frame is at least 24 bits long: a 4-bit command, then 4 unused bits, then a 16-bit data word. The converter code sits in the upper `CODE_W` bits of the data word, most significant bit first, and any remaining low bits are ignored. A host with a 16-bit minimum word can send a 32-bit frame. The block always decodes the most recent 24 bits. Frames shorter than 24 bits are dropped.

All state lives in the system clock domain. The serial pins are synchronised and edge-detected there, so the serial clock must be several times slower than the system clock. The reference default is sampled from a strap input while reset is held.

Top module: `dacif_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `dac_code` is 0 and `pwr_down` is 0. Throughout reset, `ref_internal` follows `ref_sel` (1 = internal reference, 0 = external reference).
- R2: Once reset has ended, changes on `ref_sel` have no effect on `ref_internal`.
- R3: Bit 23 of a 24-bit frame is sent first. The command is frame bits 23..20, and the code is frame bits 15..(16-CODE_W). Command 4'b0011 loads that code into both the staging and the converter register.
- R4: In a frame longer than 24 bits, only the last 24 bits shifted in are decoded.
- R5: No register changes before the select line rises. Command 4'b0000 loads staging only and leaves `dac_code` unchanged.
- R6: Command 4'b0001 copies staging into the converter register. Commands 4'b0001 and 4'b0011 both clear `pwr_down`.
- R7: Command 4'b0100 sets `pwr_down` and leaves `dac_code` unchanged.
- R8: Command 4'b0110 sets `ref_internal` to 1. Command 4'b0111 sets it to 0.
- R9: Every other command code changes nothing. The data word is ignored by all commands other than 4'b0000 and 4'b0011.
- R10: A frame with fewer than 24 serial clock rising edges changes no register.
- R11: The serial clock may be high or low when the select line falls, and the frame is decoded the same way in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_sel | input | 1 | Reference default strap, sampled only during reset |
| spi_sck | input | 1 | Serial clock, asynchronous to `clk` |
| spi_cs_n | input | 1 | Active-low select and load strobe |
| spi_sdi | input | 1 | Serial data in |
| dac_code | output | CODE_W | Converter register contents |
| pwr_down | output | 1 | Power-down state |
| ref_internal | output | 1 | 1 = internal reference, 0 = external reference |

## Verification
The bench targets the following cases:
- A 32-bit frame whose leading byte looks like a valid command. A design that decoded the first 24 bits would load the wrong code.
- A frame cut one bit short. An edge counter that is off by one would execute it.
- An update-only frame carrying a full data word. A decoder that does not gate the write would corrupt staging, which a later update exposes.
- The strap pin moving after reset, and each reserved code. Either would flip the reference or state if handled wrongly.
- A frame that starts with the serial clock high. A design that counts a stale level as an edge would lose alignment.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  localparam int FRAME_BITS = 24;
  localparam int WORD_BITS  = 16;
  localparam int CMD_BITS   = 4;

  typedef enum logic [CMD_BITS-1:0] {
    CMD_LOAD   = 4'b0000,
    CMD_COMMIT = 4'b0001,
    CMD_BOTH   = 4'b0011,
    CMD_SLEEP  = 4'b0100,
    CMD_REFINT = 4'b0110,
    CMD_REFEXT = 4'b0111
  } dac_cmd_e;
endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= RST_VAL;
        else     stage_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= RST_VAL;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dacif_shift.sv
module dacif_shift
  import dacif_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int FRAME_W = FRAME_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              sdi,
  output logic              exec_v,
  output logic [CMD_BITS-1:0] exec_cmd,
  output logic [CODE_W-1:0] exec_code
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

  logic [FRAME_W-1:0] sr_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               sck_q, cs_q;
  logic               sck_rise, cs_rise, cs_fall;

  assign sck_rise = sck & ~sck_q;
  assign cs_rise  = cs_n & ~cs_q;
  assign cs_fall  = ~cs_n & cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
      cnt_q <= '0;
      sr_q  <= '0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      if (cs_fall) begin
        cnt_q <= '0;
      end else if (!cs_n && !cs_q && sck_rise) begin
        sr_q <= {sr_q[FRAME_W-2:0], sdi};
        if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      exec_v    <= 1'b0;
      exec_cmd  <= '0;
      exec_code <= '0;
    end else begin
      exec_v    <= cs_rise && (cnt_q == FULL);
      exec_cmd  <= sr_q[FRAME_W-1 -: CMD_BITS];
      exec_code <= sr_q[WORD_BITS-1 -: CODE_W];
    end
  end
endmodule

// File: rtl/dacif_regs.sv
module dacif_regs
  import dacif_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ref_sel,
  input  logic                exec_v,
  input  logic [CMD_BITS-1:0] exec_cmd,
  input  logic [CODE_W-1:0]   exec_code,
  output logic [CODE_W-1:0]   dac_code,
  output logic                pwr_down,
  output logic                ref_internal
);
  logic [CODE_W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q      <= '0;
      dac_code     <= '0;
      pwr_down     <= 1'b0;
      ref_internal <= ref_sel;
    end else if (exec_v) begin
      case (exec_cmd)
        CMD_LOAD:   stage_q <= exec_code;
        CMD_COMMIT: begin
          dac_code <= stage_q;
          pwr_down <= 1'b0;
        end
        CMD_BOTH: begin
          stage_q  <= exec_code;
          dac_code <= exec_code;
          pwr_down <= 1'b0;
        end
        CMD_SLEEP:  pwr_down     <= 1'b1;
        CMD_REFINT: ref_internal <= 1'b1;
        CMD_REFEXT: ref_internal <= 1'b0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dacif_ctrl.sv
module dacif_ctrl
  import dacif_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_sel,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_sdi,
  output logic [CODE_W-1:0] dac_code,
  output logic              pwr_down,
  output logic              ref_internal
);
  logic [2:0]          pins_s;
  logic                exec_v;
  logic [CMD_BITS-1:0] exec_cmd;
  logic [CODE_W-1:0]   exec_code;

  dacif_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d({spi_cs_n, spi_sck, spi_sdi}), .q(pins_s)
  );

  dacif_shift #(.CODE_W(CODE_W)) u_shift (
    .clk(clk), .rst(rst), .sck(pins_s[1]), .cs_n(pins_s[2]), .sdi(pins_s[0]),
    .exec_v(exec_v), .exec_cmd(exec_cmd), .exec_code(exec_code)
  );

  dacif_regs #(.CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst(rst), .ref_sel(ref_sel), .exec_v(exec_v),
    .exec_cmd(exec_cmd), .exec_code(exec_code), .dac_code(dac_code),
    .pwr_down(pwr_down), .ref_internal(ref_internal)
  );
endmodule

// File: rtl/dacif_ctrl_chk.sv
module dacif_ctrl_chk
  import dacif_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                exec_v,
  input logic [CMD_BITS-1:0] exec_cmd,
  input logic [CODE_W-1:0]   dac_code,
  input logic                pwr_down,
  input logic                ref_internal
);
  // R1: state cleared on leaving reset
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (dac_code == '0 && !pwr_down));

  // R5 / R9 / R10 / R2: outputs move only after an executed frame
  a_r5_hold_no_exec: assert property (@(posedge clk) disable iff (rst)
    !exec_v |=> ($stable(dac_code) && $stable(pwr_down) && $stable(ref_internal)));

  // R6: update commands wake the output
  a_r6_update_wakes: assert property (@(posedge clk) disable iff (rst)
    (exec_v && (exec_cmd == CMD_COMMIT || exec_cmd == CMD_BOTH)) |=> !pwr_down);

  // R7: power-down keeps the code
  a_r7_sleep_sets: assert property (@(posedge clk) disable iff (rst)
    (exec_v && exec_cmd == CMD_SLEEP) |=> (pwr_down && $stable(dac_code)));

  // R8: reference selection
  a_r8_ref_int: assert property (@(posedge clk) disable iff (rst)
    (exec_v && exec_cmd == CMD_REFINT) |=> ref_internal);
  a_r8_ref_ext: assert property (@(posedge clk) disable iff (rst)
    (exec_v && exec_cmd == CMD_REFEXT) |=> !ref_internal);
endmodule

bind dacif_ctrl dacif_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .exec_v(exec_v), .exec_cmd(exec_cmd),
  .dac_code(dac_code), .pwr_down(pwr_down), .ref_internal(ref_internal)
);

// File: tb/test_dacif_ctrl.sv
module test_dacif_ctrl;
  localparam int CODE_W = 12;
  localparam int HALF   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_sel = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic [CODE_W-1:0] dac_code;
  logic pwr_down, ref_internal;

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  logic [CODE_W-1:0] m_stage, m_dac;
  logic m_pd, m_ref;

  always #5 clk = ~clk;

  dacif_ctrl #(.CODE_W(CODE_W)) i_dacif_ctrl (
    .clk(clk), .rst(rst), .ref_sel(ref_sel), .spi_sck(sck), .spi_cs_n(cs_n),
    .spi_sdi(sdi), .dac_code(dac_code), .pwr_down(pwr_down),
    .ref_internal(ref_internal)
  );

  function automatic logic [23:0] mk(input logic [3:0] cmd, input logic [CODE_W-1:0] code,
                                     input logic [31:0] junk);
    logic [15:0] word;
    word = {code, junk[15-CODE_W:0]};
    return {cmd, junk[23:20], word};
  endfunction

  task automatic model(input logic [3:0] cmd, input logic [CODE_W-1:0] code);
    case (cmd)
      4'b0000: m_stage = code;
      4'b0001: begin m_dac = m_stage; m_pd = 1'b0; end
      4'b0011: begin m_stage = code; m_dac = code; m_pd = 1'b0; end
      4'b0100: m_pd = 1'b1;
      4'b0110: m_ref = 1'b1;
      4'b0111: m_ref = 1'b0;
      default: ;
    endcase
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk({req, " dac_code"}, 32'(dac_code), 32'(m_dac));
    chk({req, " pwr_down"}, 32'(pwr_down), 32'(m_pd));
    chk({req, " ref_internal"}, 32'(ref_internal), 32'(m_ref));
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int nbits, input logic [31:0] bits, input logic idle_hi);
    sck = idle_hi;
    wait_clk(HALF);
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = nbits - 1; i >= 0; i--) begin
      sck = 1'b0; sdi = bits[i];
      wait_clk(HALF);
      sck = 1'b1;
      wait_clk(HALF);
    end
    cs_n = 1'b1;
    wait_clk(10);
  endtask

  task automatic frame24(input logic [3:0] cmd, input logic [CODE_W-1:0] code, input logic idle_hi);
    send(24, {8'h00, mk(cmd, code, $urandom)}, idle_hi);
    model(cmd, code);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    m_stage = '0; m_dac = '0; m_pd = 1'b0;
    // R1 reset with strap low
    ref_sel = 1'b0; rst = 1'b1; wait_clk(5); rst = 1'b0; wait_clk(2);
    m_ref = 1'b0; check_all("R1 strap low");
    // R1 reset with strap high, then R2 strap ignored
    ref_sel = 1'b1; rst = 1'b1; wait_clk(5); rst = 1'b0; wait_clk(2);
    m_ref = 1'b1; check_all("R1 strap high");
    ref_sel = 1'b0; wait_clk(8);
    check_all("R2 strap ignored");

    frame24(4'b0011, 12'hABC, 1'b0); check_all("R3 write+update");
    frame24(4'b0000, 12'h123, 1'b0); check_all("R5 write only");
    frame24(4'b0001, 12'hFFF, 1'b0); check_all("R6 R9 update ignores data");
    frame24(4'b0100, 12'h000, 1'b0); check_all("R7 power down");
    frame24(4'b0001, 12'h5A5, 1'b0); check_all("R6 update wakes");
    frame24(4'b0100, 12'h000, 1'b0);
    frame24(4'b0011, 12'h3C3, 1'b0); check_all("R6 write+update wakes");
    frame24(4'b0111, 12'h000, 1'b0); check_all("R8 external ref");
    frame24(4'b0110, 12'h000, 1'b0); check_all("R8 internal ref");
    frame24(4'b0000, 12'h0F0, 1'b0);
    frame24(4'b0010, 12'h111, 1'b0); frame24(4'b0101, 12'h222, 1'b0);
    frame24(4'b1000, 12'h333, 1'b0); frame24(4'b1111, 12'h444, 1'b0);
    check_all("R9 reserved codes");
    frame24(4'b0001, 12'h999, 1'b0); check_all("R9 staging intact");
    // R10 short frame
    send(23, {9'd0, mk(4'b0011, 12'h555, 0) >> 1}, 1'b0); check_all("R10 short frame");
    // R4 32-bit frame with decoy leading byte
    send(32, {8'h3E, mk(4'b0011, 12'h777, 0)}, 1'b0); model(4'b0011, 12'h777);
    check_all("R4 long frame");
    // R11 serial clock high at select fall
    frame24(4'b0011, 12'h468, 1'b1); check_all("R11 sck idle high");

    for (int k = 0; k < 200; k++) begin
      logic [3:0] cmd;
      logic [CODE_W-1:0] code;
      int sel;
      cmd  = 4'($urandom);
      code = CODE_W'($urandom);
      sel  = $urandom_range(0, 9);
      if (sel < 7) begin
        send(24, {8'h00, mk(cmd, code, $urandom)}, 1'($urandom));
        model(cmd, code); check_all("R3 R9 random 24");
      end else if (sel < 9) begin
        send(32, {8'($urandom), mk(cmd, code, $urandom)}, 1'($urandom));
        model(cmd, code); check_all("R4 random 32");
      end else begin
        send($urandom_range(1, 23), $urandom, 1'b0);
        check_all("R10 random short");
      end
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule